// File: doc/BRIEF.md
# Dual-Mode Oversampling Baud Tick Generator

This block derives the 16x oversampling tick that a UART serializer and deserializer run from, using only the system clock. It offers two schemes, chosen at run time by a single mode input. The first is an integer divider that issues one tick every N clocks. The second is a 16-bit phase accumulator that adds a step value on every clock and ticks on each carry out of its top bit. The accumulator gives fine rate resolution at high bit rates, where whole-number division error grows large.

A run input gates the generator. While run is low, all internal state is held at zero and nothing is emitted, which is the low-power state. A 4-bit prescaler counts oversample ticks and produces a per-bit strobe on every sixteenth one. Rate and mode changes made while running are deferred to the next tick boundary, so the tick period in progress is never cut short. Register decoding and the serial datapaths lie outside this block.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high, `os_tick` and `bit_strobe` stay low whatever the other inputs are.
- R2: With `frac_mode`=0 and `rate_word`=N (N≥2), `os_tick` pulses for one cycle every N clocks, and the first pulse follows the N-th rising clock edge at which `run_en` is sampled high.
- R3: With `frac_mode`=0 and `rate_word` equal to 0 or 1, `os_tick` is high on every clock while running, starting after the first running edge.
- R4: With `frac_mode`=1, `rate_word` is added to a 16-bit accumulator that starts at zero on every running clock, and `os_tick` pulses on each carry out of bit 15 (0x4000 gives a tick every 4 clocks, 0xFFFF a first tick after 2 clocks and then one per clock).
- R5: While `run_en` is low, no `os_tick` or `bit_strobe` is produced. When `run_en` rises again, the period restarts from zero.
- R6: `bit_strobe` pulses together with every 16th `os_tick` after run starts, and never without `os_tick`.
- R7: A change of `rate_word` or `frac_mode` while running takes effect only at the next tick, so the current period finishes at its old length.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run gate; low freezes and clears the generator |
| frac_mode | input | 1 | 0 selects the integer divider, 1 selects the phase accumulator |
| rate_word | input | RATE_W | Divisor (divider mode) or phase step (accumulator mode) |
| os_tick | output | 1 | Registered 16x oversample tick, one clock wide |
| bit_strobe | output | 1 | Registered per-bit strobe on every 16th tick |

## Verification
The hardest case to reach is a rate or mode change that lands in the middle of a running period, because the deferred value only becomes visible one full period later. The bench starts a long divider period, waits for the first tick, and changes the rate a few cycles later. It then checks that the next tick still arrives at the old spacing and only the following one at the new spacing. A second sequence switches from divider to accumulator mid-period and checks that the divider finishes its period before the accumulator takes over from zero.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  typedef enum logic {
    GEN_DIV = 1'b0,
    GEN_ACC = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/int_divider.sv
module int_divider #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [RATE_W-1:0] period,
  output logic              tick_evt
);
  logic [RATE_W-1:0] cnt;
  logic [RATE_W-1:0] per_eff;

  // Periods of 0 and 1 both mean one tick per clock.
  assign per_eff  = (period == '0) ? RATE_W'(1) : period;
  assign tick_evt = en && (cnt == per_eff - RATE_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en)    cnt <= '0;
    else if (tick_evt) cnt <= '0;
    else               cnt <= cnt + RATE_W'(1);
  end

  // R5: the counter is cleared one cycle after the enable drops
  p_div_idle_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
  // R2: the count stays inside the active period
  p_div_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < per_eff));
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [RATE_W-1:0] step,
  output logic              tick_evt
);
  logic [RATE_W-1:0] acc;
  logic [RATE_W:0]   sum;

  assign sum      = {1'b0, acc} + {1'b0, step};
  assign tick_evt = en && sum[RATE_W];

  always_ff @(posedge clk) begin
    if (rst || !en) acc <= '0;
    else            acc <= sum[RATE_W-1:0];
  end

  // R5: phase is zeroed one cycle after the enable drops
  p_acc_idle_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc == '0));
endmodule

// File: rtl/bit_prescaler.sv
module bit_prescaler #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick_evt,
  output logic strobe
);
  localparam logic [CNT_W-1:0] LAST = '1;
  logic [CNT_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pcnt   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= tick_evt && (pcnt == LAST);
      if (tick_evt) pcnt <= pcnt + CNT_W'(1);
    end
  end

  // R6: after a strobe the tick count has wrapped to zero
  p_wrap_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (pcnt == '0));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RATE_W   = 16,
  parameter int OVS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              frac_mode,
  input  logic [RATE_W-1:0] rate_word,
  output logic              os_tick,
  output logic              bit_strobe
);
  import baudgen_pkg::*;

  logic [RATE_W-1:0] rate_q;
  gen_mode_e         mode_q;
  logic              div_en, acc_en;
  logic              div_evt, acc_evt, tick_evt;

  assign div_en   = run_en && (mode_q == GEN_DIV);
  assign acc_en   = run_en && (mode_q == GEN_ACC);
  assign tick_evt = div_evt || acc_evt;

  // Settings are taken while idle or at a tick boundary only.
  always_ff @(posedge clk) begin
    if (rst || !run_en || tick_evt) begin
      rate_q <= rate_word;
      mode_q <= gen_mode_e'(frac_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) os_tick <= 1'b0;
    else     os_tick <= tick_evt;
  end

  int_divider #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .en(div_en), .period(rate_q), .tick_evt(div_evt)
  );

  phase_accum #(.RATE_W(RATE_W)) u_acc (
    .clk(clk), .rst(rst), .en(acc_en), .step(rate_q), .tick_evt(acc_evt)
  );

  bit_prescaler #(.CNT_W(OVS_LOG2)) u_pre (
    .clk(clk), .rst(rst), .en(run_en), .tick_evt(tick_evt), .strobe(bit_strobe)
  );

  // R5: nothing is emitted after an idle cycle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!os_tick && !bit_strobe));
  // R6: the per-bit strobe only accompanies an oversample tick
  p_strobe_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> os_tick);
  // R4: the two generators never fire in the same cycle
  p_one_source_r4: assert property (@(posedge clk) disable iff (rst)
    !(div_evt && acc_evt));
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst, run_en, frac_mode;
  logic [15:0] rate_word;
  logic        os_tick, bit_strobe;
  int          n_chk = 0, n_fail = 0;
  int          t;

  always #2.5 clk = ~clk;

  baud_tick_gen dut (
    .clk(clk), .rst(rst), .run_en(run_en), .frac_mode(frac_mode),
    .rate_word(rate_word), .os_tick(os_tick), .bit_strobe(bit_strobe)
  );

  typedef struct packed {
    logic        m;
    logic [15:0] r;
    logic [7:0]  first;
    logic [7:0]  gap;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 16'd5,      8'd5,  8'd5},
    '{1'b0, 16'd16,     8'd16, 8'd16},
    '{1'b0, 16'd1,      8'd1,  8'd1},
    '{1'b0, 16'd0,      8'd1,  8'd1},
    '{1'b1, 16'h8000,   8'd2,  8'd2},
    '{1'b1, 16'h4000,   8'd4,  8'd4},
    '{1'b1, 16'h2000,   8'd8,  8'd8},
    '{1'b1, 16'hFFFF,   8'd2,  8'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts running edges until os_tick (or bit_strobe) is seen.
  task automatic wait_evt(input bit strb, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!(strb ? bit_strobe : os_tick) && n < 400);
  endtask

  task automatic start(input logic m, input logic [15:0] r);
    @(negedge clk);
    run_en = 1'b0; frac_mode = m; rate_word = r;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; run_en = 1'b1; frac_mode = 1'b0; rate_word = 16'd1;
    // R1: outputs stay low through reset even when running at full rate
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 os_tick", os_tick, 0);
      check("R1 bit_strobe", bit_strobe, 0);
    end
    run_en = 1'b0;
    @(negedge clk); rst = 1'b0;

    // R2 R3 R4: table walk, first-tick latency and steady spacing
    foreach (VECS[i]) begin
      start(VECS[i].m, VECS[i].r);
      wait_evt(1'b0, t);
      check(VECS[i].m ? "R4 first" : (VECS[i].r <= 1 ? "R3 first" : "R2 first"),
            t, int'(VECS[i].first));
      wait_evt(1'b0, t);
      check(VECS[i].m ? "R4 gap" : (VECS[i].r <= 1 ? "R3 gap" : "R2 gap"),
            t, int'(VECS[i].gap));
    end

    // R6: strobe on the 16th and 32nd tick at one tick per clock
    start(1'b0, 16'd1);
    wait_evt(1'b1, t);
    check("R6 first strobe", t, 16);
    check("R6 tick with strobe", os_tick, 1);
    wait_evt(1'b1, t);
    check("R6 second strobe", t, 16);

    // R5: idle produces nothing, restart counts from zero
    @(negedge clk); run_en = 1'b0;
    t = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (os_tick || bit_strobe) t++;
    end
    check("R5 idle pulses", t, 0);
    rate_word = 16'd7;
    @(negedge clk); run_en = 1'b1;
    wait_evt(1'b0, t);
    check("R5 restart latency", t, 7);

    // R7: rate change mid-period is deferred
    start(1'b0, 16'd10);
    wait_evt(1'b0, t);
    check("R7 base period", t, 10);
    repeat (3) @(negedge clk);
    rate_word = 16'd4;
    wait_evt(1'b0, t);
    check("R7 old period kept", t, 10 - 3);
    wait_evt(1'b0, t);
    check("R7 new period", t, 4);

    // R7: mode switch mid-period; accumulator starts from zero after the tick
    start(1'b0, 16'd6);
    wait_evt(1'b0, t);
    check("R7 div period", t, 6);
    repeat (2) @(negedge clk);
    frac_mode = 1'b1; rate_word = 16'h4000;
    wait_evt(1'b0, t);
    check("R7 div finishes", t, 6 - 2);
    wait_evt(1'b0, t);
    check("R7 acc after switch", t, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule